// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a DDR2-class SDRAM device from power-on to a usable state. After reset it keeps the clock-enable, on-die termination and device reset pins low and issues no command. When `start` is seen in the idle state, it walks a fixed twelve-step script and puts one command on the strobe, bank and row-address outputs per step. After each step it counts its own wait before the next step. When the last step is done, it raises `done` and holds it until the next reset.

The script runs in this order:

1. Power-up: clock enable, termination and device reset are raised, followed by a long settle wait.
2. A precharge of all banks.
3. Extended mode register loads on banks 3, 2 and 1, each with zero.
4. A mode register load with the DLL-reset bit set, followed by a medium wait.
5. A second precharge of all banks.
6. Two auto-refreshes, each followed by a short wait.
7. A mode register load without the DLL-reset bit, followed by a medium wait.
8. An extended mode register 1 load that enters the default off-chip-driver calibration.
9. An extended mode register 1 load that exits calibration.

The parameters set the CAS latency, the burst length, the write recovery and the three wait lengths.

The controller has four states:

- `ST_IDLE` moves to `ST_ISSUE` on `start`.
- `ST_ISSUE` drives the current step for one cycle. If the step's wait is zero it goes straight to the next `ST_ISSUE`, or to `ST_DONE` after the last step. Otherwise it loads the timer and moves to `ST_WAIT`.
- `ST_WAIT` counts the wait down, then advances the same way.
- `ST_DONE` is terminal until reset.

Top module: `sdr_init_seq`

## Requirements
- R1: While `rst_n` is low, and in the idle state after reset until `start` is sampled high, `cke`, `odt` and `reset_n` are 0, all four strobes are 0, `bank` and `addr` are 0, and `done` is 0. A synchronous reset taken in the middle of the script restores this state on the next cycle.
- R2: In the cycle after `start` is sampled high in idle, `cke`, `odt` and `reset_n` go high together with no strobe active. They stay high until reset. The next WAIT_CKE cycles are NOP cycles.
- R3: The strobes are active high, packed as {cs,ras,cas,we}. Precharge-all is 1101, mode-register-set is 1111, auto-refresh is 1110 and NOP is 0000. Each command lasts one cycle. In every cycle that is not a command, the strobes are 0000 and `bank` and `addr` are 0.
- R4: Each precharge-all drives `addr` = 0x400 (A10 high) on bank 0. The next step is issued on the following cycle.
- R5: After the first precharge, back to back, come mode-register-set commands on bank 3, bank 2 and bank 1, in that order, each with `addr` = 0.
- R6: The next command is a mode-register-set on bank 0 with `addr` = log2(BURST_LEN) + (CAS_LAT<<4) + (WR_REC<<9) + 0x100. The 0x100 term is the DLL-reset bit, and the default value is 0x532. WAIT_MRS NOP cycles follow it.
- R7: A second precharge-all (R4 form) follows. Then come two auto-refreshes with bank 0 and `addr` 0, each followed by WAIT_REF NOP cycles.
- R8: Next comes a mode-register-set on bank 0 with the R6 value minus the DLL-reset bit (default 0x432), followed by WAIT_MRS NOP cycles.
- R9: Last, back to back, come a mode-register-set on bank 1 with `addr` = 0x380 and then one on bank 1 with `addr` = 0. `done` rises on the cycle after the second one.
- R10: `done` stays high until reset. From the first command until reset, `start` has no effect: it neither restarts nor disturbs the script, and no command appears after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins the script when sampled high in idle |
| cke | output | 1 | SDRAM clock enable |
| odt | output | 1 | On-die termination enable |
| reset_n | output | 1 | SDRAM device reset release (high = released) |
| cmd_cs | output | 1 | Chip-select strobe, active high |
| cmd_ras | output | 1 | Row strobe, active high |
| cmd_cas | output | 1 | Column strobe, active high |
| cmd_we | output | 1 | Write-enable strobe, active high |
| bank | output | BANK_W | Bank address of the current command |
| addr | output | ROW_W | Row address bus of the current command |
| done | output | 1 | Script complete, held until reset |

## Verification
The assertions rely on `rst_n` being sampled high or low on clock edges only. `start` may take any value in any cycle, since the block must ignore it outside idle. The bench therefore holds `start` high for a whole run and pulses it after `done`, to show that neither disturbs the script. It also drops reset partway through the long power-up wait and checks that the script restarts from the first step.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_PREA,
        OP_MRS,
        OP_REF
    } sdram_op_t;

    typedef struct packed {
        logic cs;
        logic ras;
        logic cas;
        logic we;
    } strobe_t;

endpackage

// File: rtl/sdr_init_script.sv
module sdr_init_script
    import sdr_init_pkg::*;
#(
    parameter int ROW_W     = 14,
    parameter int BANK_W    = 3,
    parameter int STEP_W    = 4,
    parameter int WAIT_W    = 15,
    parameter int NUM_STEPS = 12,
    parameter int MR_BASE   = 1074,
    parameter int WAIT_CKE  = 20000,
    parameter int WAIT_MRS  = 200,
    parameter int WAIT_REF  = 4
) (
    input  logic [STEP_W-1:0] step,
    output sdram_op_t         op,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  addr,
    output logic [WAIT_W-1:0] wait_len,
    output logic              last
);
    localparam int DLL_RST  = 1 << 8;
    localparam int OCD_DFLT = 7 << 7;
    localparam int A10      = 1 << 10;

    always_comb begin
        op       = OP_NOP;
        bank     = '0;
        addr     = '0;
        wait_len = '0;
        unique case (step)
            4'd0:  wait_len = WAIT_W'(WAIT_CKE);
            4'd1:  begin op = OP_PREA; addr = ROW_W'(A10); end
            4'd2:  begin op = OP_MRS;  bank = BANK_W'(3); end
            4'd3:  begin op = OP_MRS;  bank = BANK_W'(2); end
            4'd4:  begin op = OP_MRS;  bank = BANK_W'(1); end
            4'd5:  begin op = OP_MRS;  addr = ROW_W'(MR_BASE + DLL_RST);
                         wait_len = WAIT_W'(WAIT_MRS); end
            4'd6:  begin op = OP_PREA; addr = ROW_W'(A10); end
            4'd7:  begin op = OP_REF;  wait_len = WAIT_W'(WAIT_REF); end
            4'd8:  begin op = OP_REF;  wait_len = WAIT_W'(WAIT_REF); end
            4'd9:  begin op = OP_MRS;  addr = ROW_W'(MR_BASE);
                         wait_len = WAIT_W'(WAIT_MRS); end
            4'd10: begin op = OP_MRS;  bank = BANK_W'(1); addr = ROW_W'(OCD_DFLT); end
            4'd11: begin op = OP_MRS;  bank = BANK_W'(1); end
            default: ;
        endcase
    end

    assign last = (step == STEP_W'(NUM_STEPS - 1));

endmodule

// File: rtl/sdr_init_timer.sv
module sdr_init_timer #(
    parameter int WAIT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - WAIT_W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdr_init_cmd_enc.sv
module sdr_init_cmd_enc
    import sdr_init_pkg::*;
(
    input  sdram_op_t op,
    input  logic      en,
    output strobe_t   strb
);
    always_comb begin
        strb = '0;
        if (en) begin
            unique case (op)
                OP_PREA: strb = '{cs: 1'b1, ras: 1'b1, cas: 1'b0, we: 1'b1};
                OP_MRS:  strb = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b1};
                OP_REF:  strb = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b0};
                OP_NOP:  strb = '0;
            endcase
        end
    end

endmodule

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
    import sdr_init_pkg::*;
#(
    parameter int ROW_W     = 14,
    parameter int BANK_W    = 3,
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4,
    parameter int WR_REC    = 2,
    parameter int WAIT_CKE  = 20000,
    parameter int WAIT_MRS  = 200,
    parameter int WAIT_REF  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cke,
    output logic              odt,
    output logic              reset_n,
    output logic              cmd_cs,
    output logic              cmd_ras,
    output logic              cmd_cas,
    output logic              cmd_we,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  addr,
    output logic              done
);
    localparam int NUM_STEPS = 12;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int MAX_WAIT  = (WAIT_CKE > WAIT_MRS) ?
                               ((WAIT_CKE > WAIT_REF) ? WAIT_CKE : WAIT_REF) :
                               ((WAIT_MRS > WAIT_REF) ? WAIT_MRS : WAIT_REF);
    localparam int WAIT_W    = $clog2(MAX_WAIT + 1);
    localparam int MR_BASE   = $clog2(BURST_LEN) + (CAS_LAT << 4) + (WR_REC << 9);

    seq_state_t        state, state_nxt;
    logic [STEP_W-1:0] step, step_nxt;
    logic              powered;

    sdram_op_t         sc_op;
    logic [BANK_W-1:0] sc_bank;
    logic [ROW_W-1:0]  sc_addr;
    logic [WAIT_W-1:0] sc_wait;
    logic              sc_last;

    logic              tmr_load, tmr_run, tmr_expired;
    logic              issuing;
    strobe_t           strb;

    sdr_init_script #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .STEP_W(STEP_W), .WAIT_W(WAIT_W),
        .NUM_STEPS(NUM_STEPS), .MR_BASE(MR_BASE), .WAIT_CKE(WAIT_CKE),
        .WAIT_MRS(WAIT_MRS), .WAIT_REF(WAIT_REF)
    ) u_script (
        .step(step), .op(sc_op), .bank(sc_bank), .addr(sc_addr),
        .wait_len(sc_wait), .last(sc_last)
    );

    sdr_init_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(sc_wait - WAIT_W'(1)), .run(tmr_run), .expired(tmr_expired)
    );

    sdr_init_cmd_enc u_enc (.op(sc_op), .en(issuing), .strb(strb));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            step    <= '0;
            powered <= 1'b0;
        end else begin
            state <= state_nxt;
            step  <= step_nxt;
            if (state == ST_IDLE && start)
                powered <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        step_nxt  = step;
        tmr_load  = 1'b0;
        tmr_run   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_ISSUE;
                    step_nxt  = '0;
                end
            end
            ST_ISSUE: begin
                if (sc_wait == '0) begin
                    if (sc_last) state_nxt = ST_DONE;
                    else step_nxt = step + STEP_W'(1);
                end else begin
                    tmr_load  = 1'b1;
                    state_nxt = ST_WAIT;
                end
            end
            ST_WAIT: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    if (sc_last) begin
                        state_nxt = ST_DONE;
                    end else begin
                        state_nxt = ST_ISSUE;
                        step_nxt  = step + STEP_W'(1);
                    end
                end
            end
            ST_DONE: ;
        endcase
    end

    // Outputs
    always_comb begin
        issuing = (state == ST_ISSUE);
        cke     = powered;
        odt     = powered;
        reset_n = powered;
        cmd_cs  = strb.cs;
        cmd_ras = strb.ras;
        cmd_cas = strb.cas;
        cmd_we  = strb.we;
        bank    = issuing ? sc_bank : '0;
        addr    = issuing ? sc_addr : '0;
        done    = (state == ST_DONE);
    end

endmodule

// File: rtl/sdr_init_seq_chk.sv
module sdr_init_seq_chk #(
    parameter int ROW_W     = 14,
    parameter int BANK_W    = 3,
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4,
    parameter int WR_REC    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cke,
    input logic              odt,
    input logic              reset_n,
    input logic              cmd_cs,
    input logic              cmd_ras,
    input logic              cmd_cas,
    input logic              cmd_we,
    input logic [BANK_W-1:0] bank,
    input logic [ROW_W-1:0]  addr,
    input logic              done
);
    localparam int MR_V = $clog2(BURST_LEN) + (CAS_LAT << 4) + (WR_REC << 9);

    logic is_prea, is_ref, is_mrs;
    assign is_prea = cmd_cs && cmd_ras && !cmd_cas && cmd_we;
    assign is_ref  = cmd_cs && cmd_ras && cmd_cas && !cmd_we;
    assign is_mrs  = cmd_cs && cmd_ras && cmd_cas && cmd_we;

    assert_strobe_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ras || cmd_cas || cmd_we) |-> cmd_cs);

    assert_cmd_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cs |-> (is_prea || is_ref || is_mrs));

    assert_cmd_powered_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cs |-> (cke && odt && reset_n));

    assert_power_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && odt && reset_n) |=> (cke && odt && reset_n));

    assert_prea_a10_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_prea |-> (addr == ROW_W'(1 << 10) && bank == '0));

    assert_ref_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (addr == '0 && bank == '0));

    assert_mr0_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrs && bank == '0) |->
            (addr == ROW_W'(MR_V) || addr == ROW_W'(MR_V + (1 << 8))));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !cmd_cs);

endmodule

bind sdr_init_seq sdr_init_seq_chk #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .CAS_LAT(CAS_LAT),
    .BURST_LEN(BURST_LEN), .WR_REC(WR_REC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cke(cke), .odt(odt),
    .reset_n(reset_n), .cmd_cs(cmd_cs), .cmd_ras(cmd_ras), .cmd_cas(cmd_cas),
    .cmd_we(cmd_we), .bank(bank), .addr(addr), .done(done)
);

// File: tb/tb_sdr_init_seq.sv
module tb_sdr_init_seq;
    localparam int ROW_W = 14;
    localparam int BANK_W = 3;
    localparam int CL = 3, BL = 4, WR = 2;
    localparam int W_CKE = 20000, W_MRS = 200, W_REF = 4;
    localparam int MRV = $clog2(BL) + CL * 16 + WR * 512;

    localparam logic [3:0] S_NOP = 4'b0000, S_PREA = 4'b1101,
                           S_MRS = 4'b1111, S_REF = 4'b1110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cke, odt, reset_n, cmd_cs, cmd_ras, cmd_cas, cmd_we, done;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0] addr;

    int vectors = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdr_init_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cke(cke), .odt(odt),
        .reset_n(reset_n), .cmd_cs(cmd_cs), .cmd_ras(cmd_ras), .cmd_cas(cmd_cas),
        .cmd_we(cmd_we), .bank(bank), .addr(addr), .done(done)
    );

    task automatic expect_out(input string req, input logic pw, input logic [3:0] strb,
                              input int bk, input int ad, input logic dn);
        logic [3+3+4+BANK_W+ROW_W-1:0] act, exp;
        act = {cke, odt, reset_n, cmd_cs, cmd_ras, cmd_cas, cmd_we, bank, addr, done, 2'b00};
        exp = {pw, pw, pw, strb, BANK_W'(bk), ROW_W'(ad), dn, 2'b00};
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t act=%h exp=%h", req, $time, act, exp);
        end
    endtask

    // At a negedge where step is issued: check it, its wait, and move to next issue cycle.
    task automatic step(input string req, input logic [3:0] strb, input int bk,
                        input int ad, input int w);
        expect_out(req, 1'b1, strb, bk, ad, 1'b0);
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            expect_out(req, 1'b1, S_NOP, 0, 0, 1'b0);
        end
        @(negedge clk);
    endtask

    task automatic run_script();
        step("R2", S_NOP, 0, 0, W_CKE);
        step("R4", S_PREA, 0, 'h400, 0);
        step("R5", S_MRS, 3, 0, 0);
        step("R5", S_MRS, 2, 0, 0);
        step("R5", S_MRS, 1, 0, 0);
        step("R6", S_MRS, 0, MRV + 'h100, W_MRS);
        step("R7", S_PREA, 0, 'h400, 0);
        step("R7", S_REF, 0, 0, W_REF);
        step("R7", S_REF, 0, 0, W_REF);
        step("R8", S_MRS, 0, MRV, W_MRS);
        step("R9", S_MRS, 1, 'h380, 0);
        step("R9", S_MRS, 1, 0, 0);
        expect_out("R9", 1'b1, S_NOP, 0, 0, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: held in reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            expect_out("R1", 1'b0, S_NOP, 0, 0, 1'b0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            expect_out("R1", 1'b0, S_NOP, 0, 0, 1'b0);
        end
        // Run 1: single start pulse
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_script();
        // R10: done holds, start pulses do nothing
        for (int i = 0; i < 20; i++) begin
            start = (i % 3 == 0);
            @(negedge clk);
            expect_out("R10", 1'b1, S_NOP, 0, 0, 1'b1);
        end
        start = 1'b0;
        // Reset, then start held high for the whole run
        rst_n = 1'b0;
        @(negedge clk);
        expect_out("R1", 1'b0, S_NOP, 0, 0, 1'b0);
        rst_n = 1'b1;
        start = 1'b1;
        @(negedge clk);
        run_script();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            expect_out("R10", 1'b1, S_NOP, 0, 0, 1'b1);
        end
        // Reset partway through the power-up wait
        rst_n = 1'b0;
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 50; i++) begin
            expect_out("R2", 1'b1, S_NOP, 0, 0, 1'b0);
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        expect_out("R1", 1'b0, S_NOP, 0, 0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            expect_out("R1", 1'b0, S_NOP, 0, 0, 1'b0);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_script();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule